// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of one progressive video frame on a pixel clock. A pixel counter and a line counter walk the frame. Six timing outputs are decoded from them and from a programmed timing set: horizontal sync, vertical sync, horizontal blanking, vertical blanking, active video and active chroma. A single-cycle frame-sync pulse fires at a programmable pixel and line. Each of the six timing outputs has its own polarity bit. Vertical blanking and vertical sync switch at a programmable pixel inside their start and end lines, not only at the line edge.

Software writes a word-addressed register port. Timing registers land in shadow copies. An update request copies the whole shadow set into the working set at the last pixel of a frame, so a frame is never built from two settings. While the generator is stopped, the request takes effect on the next clock. Sticky status bits record the start of vertical blanking, the start of active video and the frame-sync pulse. Writing a one to a status bit clears it. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `raster_timing_gen`

## Requirements
- R1: Register map by word address: 0 control, 1 status, 2 active size (width bits 12:0, height bits 28:16), 3 pixels per line (bits 12:0), 4 lines per frame (bits 12:0), 5 hsync (start 12:0, end 28:16), 6 vsync lines (start 12:0, end 28:16), 7 vblank pixel offsets (assert 12:0, release 28:16), 8 vsync pixel offsets (assert 12:0, release 28:16), 9 polarity (bits 5:0), 10 frame-sync position (pixel 12:0, line 28:16). Timing registers read back their shadow value, with unused bits as zero. Unmapped addresses read zero.
- R2: While enabled, the pixel counter counts 0 to pixels-per-line minus 1 and then wraps. On each wrap the line counter advances, and it wraps after lines-per-frame minus 1. Every output is registered and reflects the position one clock earlier.
- R3: Writing control bit 1 sets an update request, which reads back as control bit 1. The shadow set moves to the working set at the edge that leaves the last pixel of the last line, or on the next edge while the generator is disabled. The request bit then clears.
- R4: Horizontal blanking is asserted for pixel >= active width. Active video and active chroma are asserted for pixel < active width and line < active height.
- R5: Horizontal sync is asserted for start <= pixel < end. A start value is inclusive and an end value is exclusive.
- R6: Vertical blanking is asserted from line = active height at the pixel given by its assert offset, through the end of the frame, and on line 0 before its release offset. Vertical sync is asserted from (start line, assert pixel) up to but excluding (end line, release pixel). Offsets of zero switch at the first pixel of the line.
- R7: The frame-sync output is an active-high pulse one clock long. It is produced each time the counters reach the programmed pixel and line while the generator is enabled.
- R8: Polarity bit map: vblank 0, hblank 1, vsync 2, hsync 3, active video 4, active chroma 5. A set bit makes the output high when asserted. Control bit 2 enables generation. While that bit is zero, the counters sit at pixel 0, line 0, and each output holds its inactive level.
- R9: Status bit 12 sets when vertical blanking begins, bit 13 when active video begins, and bit 16 on a frame-sync pulse. The bits stay set until a status write with a one in that bit position. A new event in the same clock as a clear keeps the bit set.
- R10: After reset the generator is disabled, the timing registers and status are zero, the polarity register is 0x3F, no update is pending, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| vblank_o | output | 1 | Vertical blanking |
| hblank_o | output | 1 | Horizontal blanking |
| vsync_o | output | 1 | Vertical sync |
| hsync_o | output | 1 | Horizontal sync |
| active_video_o | output | 1 | Active video |
| active_chroma_o | output | 1 | Active chroma |
| fsync_o | output | 1 | Frame-sync pulse, active high |

## Verification
The counter-bound check assumes software never enables the generator with a working set whose line length is zero. The bench always programs and commits a complete timing set before it sets the enable bit. The update checks assume that update requests are not issued in the same clock as the frame's last pixel. Every mid-frame update request in the stimulus is issued well inside the frame. Sync windows are always programmed with the start position before the end position.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int COORD_W = 13;
  localparam int HI_LSB  = 16;
  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;
  localparam int N_OUT   = 6;

  // output index, also the polarity bit position
  localparam int O_VBLANK = 0;
  localparam int O_HBLANK = 1;
  localparam int O_VSYNC  = 2;
  localparam int O_HSYNC  = 3;
  localparam int O_ACTIVE = 4;
  localparam int O_CHROMA = 5;

  // status bit positions
  localparam int ST_VBLANK = 12;
  localparam int ST_ACTIVE = 13;
  localparam int ST_FSYNC  = 16;

  // control bit positions
  localparam int CT_UPDATE = 1;
  localparam int CT_ENABLE = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 4'd0,
    RA_STAT   = 4'd1,
    RA_ACTIVE = 4'd2,
    RA_HTOT   = 4'd3,
    RA_VTOT   = 4'd4,
    RA_HSYNC  = 4'd5,
    RA_VSLINE = 4'd6,
    RA_VBOFF  = 4'd7,
    RA_VSOFF  = 4'd8,
    RA_POL    = 4'd9,
    RA_FSYNC  = 4'd10
  } reg_addr_e;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t           hact;
    coord_t           vact;
    coord_t           htot;
    coord_t           vtot;
    coord_t           hs_beg;
    coord_t           hs_end;
    coord_t           vs_beg;
    coord_t           vs_end;
    coord_t           vb_hbeg;
    coord_t           vb_hend;
    coord_t           vs_hbeg;
    coord_t           vs_hend;
    coord_t           fs_h;
    coord_t           fs_v;
    logic [N_OUT-1:0] pol;
  } timing_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = REG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          frame_end,
  input  logic [2:0]    sts_set,
  output logic          gen_en,
  output timing_cfg_t   work
);
  localparam int CW = COORD_W;

  timing_cfg_t shadow;
  logic        pending;
  logic [2:0]  sts;

  coord_t lo_f, hi_f;
  assign lo_f = wdata[CW-1:0];
  assign hi_f = wdata[HI_LSB +: CW];

  logic wr_ctrl, wr_stat, commit;
  assign wr_ctrl = wr_en && (addr == RA_CTRL);
  assign wr_stat = wr_en && (addr == RA_STAT);
  assign commit  = pending && (!gen_en || frame_end);

  logic [2:0] clr_mask;
  assign clr_mask = wr_stat ? {wdata[ST_FSYNC], wdata[ST_ACTIVE], wdata[ST_VBLANK]} : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      shadow.pol <= '1;
      work       <= '0;
      work.pol   <= '1;
      pending    <= 1'b0;
      gen_en     <= 1'b0;
      sts        <= '0;
    end else begin
      if (commit) begin
        work    <= shadow;
        pending <= 1'b0;
      end
      if (wr_ctrl) begin
        gen_en <= wdata[CT_ENABLE];
        if (wdata[CT_UPDATE]) pending <= 1'b1;
      end
      sts <= (sts & ~clr_mask) | sts_set;
      if (wr_en) begin
        case (addr)
          RA_ACTIVE: begin shadow.hact   <= lo_f; shadow.vact    <= hi_f; end
          RA_HTOT:          shadow.htot  <= lo_f;
          RA_VTOT:          shadow.vtot  <= lo_f;
          RA_HSYNC:  begin shadow.hs_beg <= lo_f; shadow.hs_end  <= hi_f; end
          RA_VSLINE: begin shadow.vs_beg <= lo_f; shadow.vs_end  <= hi_f; end
          RA_VBOFF:  begin shadow.vb_hbeg <= lo_f; shadow.vb_hend <= hi_f; end
          RA_VSOFF:  begin shadow.vs_hbeg <= lo_f; shadow.vs_hend <= hi_f; end
          RA_POL:           shadow.pol   <= wdata[N_OUT-1:0];
          RA_FSYNC:  begin shadow.fs_h   <= lo_f; shadow.fs_v    <= hi_f; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [DW-1:0] pair(input coord_t lo, input coord_t hi);
    logic [DW-1:0] w;
    w = '0;
    w[CW-1:0] = lo;
    w[HI_LSB +: CW] = hi;
    return w;
  endfunction

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CT_ENABLE] = gen_en;
        rdata[CT_UPDATE] = pending;
      end
      RA_STAT: begin
        rdata[ST_VBLANK] = sts[0];
        rdata[ST_ACTIVE] = sts[1];
        rdata[ST_FSYNC]  = sts[2];
      end
      RA_ACTIVE: rdata = pair(shadow.hact, shadow.vact);
      RA_HTOT:   rdata[CW-1:0] = shadow.htot;
      RA_VTOT:   rdata[CW-1:0] = shadow.vtot;
      RA_HSYNC:  rdata = pair(shadow.hs_beg, shadow.hs_end);
      RA_VSLINE: rdata = pair(shadow.vs_beg, shadow.vs_end);
      RA_VBOFF:  rdata = pair(shadow.vb_hbeg, shadow.vb_hend);
      RA_VSOFF:  rdata = pair(shadow.vs_hbeg, shadow.vs_hend);
      RA_POL:    rdata[N_OUT-1:0] = shadow.pol;
      RA_FSYNC:  rdata = pair(shadow.fs_h, shadow.fs_v);
      default:   rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DW-1:HI_LSB+CW], wdata[HI_LSB-1:CW], wdata[0]};

  // working set moves only when an update had been requested
  AST_CFG_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(work) |-> $past(pending)); // R3

  // a set status bit survives unless its clear bit was written
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(sts & ~clr_mask)) |=> (($past(sts & ~clr_mask) & ~sts) == 3'b000)); // R9
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
#(
  parameter int CW = COORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] h,
  output logic [CW-1:0] v,
  output logic          frame_end
);
  logic h_last, v_last;
  assign h_last    = (h == htot - 1'b1);
  assign v_last    = (v == vtot - 1'b1);
  assign frame_end = en && h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      h <= '0;
      v <= '0;
    end else if (h_last) begin
      h <= '0;
      v <= v_last ? '0 : v + 1'b1;
    end else begin
      h <= h + 1'b1;
    end
  end

  // the pixel position never leaves the programmed line length
  AST_PIX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (htot != '0) |-> (h < htot)); // R2
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int CW = COORD_W,
  parameter int NO = N_OUT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  timing_cfg_t   cfg,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] v,
  output logic [NO-1:0] out_q,
  output logic          fsync_q,
  output logic [2:0]    sts_set
);
  logic [NO-1:0] raw, raw_g, raw_q, lvl, rise;
  logic          fs_d;

  logic vb_tail, vb_head, vs_after, vs_before, in_active;
  always_comb begin
    vb_tail   = (v > cfg.vact) || ((v == cfg.vact) && (h >= cfg.vb_hbeg));
    vb_head   = (v == '0) && (h < cfg.vb_hend);
    vs_after  = (v > cfg.vs_beg) || ((v == cfg.vs_beg) && (h >= cfg.vs_hbeg));
    vs_before = (v < cfg.vs_end) || ((v == cfg.vs_end) && (h < cfg.vs_hend));
    in_active = (h < cfg.hact) && (v < cfg.vact);
    raw           = '0;
    raw[O_VBLANK] = vb_tail || vb_head;
    raw[O_HBLANK] = (h >= cfg.hact);
    raw[O_VSYNC]  = vs_after && vs_before;
    raw[O_HSYNC]  = (h >= cfg.hs_beg) && (h < cfg.hs_end);
    raw[O_ACTIVE] = in_active;
    raw[O_CHROMA] = in_active;
  end

  assign raw_g = en ? raw : '0;
  assign fs_d  = en && (h == cfg.fs_h) && (v == cfg.fs_v);
  assign rise  = raw_g & ~raw_q;

  for (genvar i = 0; i < NO; i++) begin : g_pol
    assign lvl[i] = raw_g[i] ? cfg.pol[i] : ~cfg.pol[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      raw_q   <= '0;
      fsync_q <= 1'b0;
    end else begin
      out_q   <= lvl;
      raw_q   <= raw_g;
      fsync_q <= fs_d;
    end
  end

  assign sts_set = {fs_d, rise[O_ACTIVE], rise[O_VBLANK]};

  // disabled generator drives the inactive level on the next clock
  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_q == ~$past(cfg.pol))); // R8

  // a frame-sync pulse only follows an enabled cycle
  AST_FSYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    fsync_q |-> $past(en)); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        vblank_o,
  output logic        hblank_o,
  output logic        vsync_o,
  output logic        hsync_o,
  output logic        active_video_o,
  output logic        active_chroma_o,
  output logic        fsync_o
);
  timing_cfg_t      work;
  logic             gen_en, frame_end;
  coord_t           h, v;
  logic [N_OUT-1:0] outs;
  logic [2:0]       sts_set;

  rtg_regs #(.AW(REG_AW), .DW(REG_DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_end(frame_end), .sts_set(sts_set),
    .gen_en(gen_en), .work(work)
  );

  rtg_counters #(.CW(COORD_W)) u_cnt (
    .clk(clk), .rst(rst), .en(gen_en), .htot(work.htot), .vtot(work.vtot),
    .h(h), .v(v), .frame_end(frame_end)
  );

  rtg_decode #(.CW(COORD_W), .NO(N_OUT)) u_dec (
    .clk(clk), .rst(rst), .en(gen_en), .cfg(work), .h(h), .v(v),
    .out_q(outs), .fsync_q(fsync_o), .sts_set(sts_set)
  );

  assign vblank_o        = outs[O_VBLANK];
  assign hblank_o        = outs[O_HBLANK];
  assign vsync_o         = outs[O_VSYNC];
  assign hsync_o         = outs[O_HSYNC];
  assign active_video_o  = outs[O_ACTIVE];
  assign active_chroma_o = outs[O_CHROMA];
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic vblank_o, hblank_o, vsync_o, hsync_o, active_video_o, active_chroma_o, fsync_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vblank_o(vblank_o), .hblank_o(hblank_o), .vsync_o(vsync_o),
    .hsync_o(hsync_o), .active_video_o(active_video_o), .active_chroma_o(active_chroma_o),
    .fsync_o(fsync_o)
  );

  // ---------------- reference model (built from the requirements) ----------
  logic [31:0] m_sh [16];
  logic [31:0] m_ac [16];
  logic        m_en, m_pend;
  logic [12:0] m_h, m_v;
  logic [2:0]  m_sts;
  logic [5:0]  m_rawq;
  logic [6:0]  exp_q [$];

  function automatic logic [31:0] fmask(input int a);
    case (a)
      2, 5, 6, 7, 8, 10: return 32'h1FFF_1FFF;
      3, 4:              return 32'h0000_1FFF;
      9:                 return 32'h0000_003F;
      default:           return 32'h0;
    endcase
  endfunction

  function automatic logic [12:0] lo(input logic [31:0] w); return w[12:0]; endfunction
  function automatic logic [12:0] hi(input logic [31:0] w); return w[28:16]; endfunction

  function automatic logic [5:0] model_raw(input logic [12:0] h, input logic [12:0] v);
    logic [25:0] key;
    logic [5:0]  r;
    key  = {v, h};
    r    = '0;
    r[0] = (key >= {hi(m_ac[2]), lo(m_ac[7])}) || (key < {13'd0, hi(m_ac[7])});
    r[1] = h >= lo(m_ac[2]);
    r[2] = (key >= {lo(m_ac[6]), lo(m_ac[8])}) && (key < {hi(m_ac[6]), hi(m_ac[8])});
    r[3] = (h >= lo(m_ac[5])) && (h < hi(m_ac[5]));
    r[4] = (h < lo(m_ac[2])) && (v < hi(m_ac[2]));
    r[5] = r[4];
    return r;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] w;
    w = '0;
    if (a == 0) begin w[2] = m_en; w[1] = m_pend; end
    else if (a == 1) begin w[12] = m_sts[0]; w[13] = m_sts[1]; w[16] = m_sts[2]; end
    else if (a < 16) w = m_sh[a];
    return w;
  endfunction

  always @(posedge clk) begin : model
    logic [5:0]  rg, rise, pol;
    logic        fs, fend, commit;
    logic [12:0] htot, vtot;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
      m_sh[9] = 32'h3F; m_ac[9] = 32'h3F;
      m_en = 0; m_pend = 0; m_h = 0; m_v = 0; m_sts = 0; m_rawq = 0;
      exp_q.delete();
    end else begin
      pol  = m_ac[9][5:0];
      rg   = m_en ? model_raw(m_h, m_v) : 6'd0;
      fs   = m_en && (m_h == lo(m_ac[10])) && (m_v == hi(m_ac[10]));
      exp_q.push_back({fs, ~(rg ^ pol)});
      rise   = rg & ~m_rawq;
      m_rawq = rg;
      if (reg_wr && reg_addr == 4'd1)
        m_sts = m_sts & ~{reg_wdata[16], reg_wdata[13], reg_wdata[12]};
      m_sts = m_sts | {fs, rise[4], rise[0]};
      htot   = lo(m_ac[3]);
      vtot   = lo(m_ac[4]);
      fend   = m_en && (m_h == htot - 13'd1) && (m_v == vtot - 13'd1);
      commit = m_pend && (!m_en || fend);
      if (!m_en) begin m_h = 0; m_v = 0; end
      else if (m_h == htot - 13'd1) begin
        m_h = 0;
        m_v = (m_v == vtot - 13'd1) ? 13'd0 : m_v + 13'd1;
      end else m_h = m_h + 13'd1;
      if (commit) begin
        for (int i = 0; i < 16; i++) m_ac[i] = m_sh[i];
        m_pend = 0;
      end
      if (reg_wr) begin
        if (reg_addr == 4'd0) begin
          m_en = reg_wdata[2];
          if (reg_wdata[1]) m_pend = 1;
        end else if (reg_addr >= 4'd2)
          m_sh[reg_addr] = reg_wdata & fmask(int'(reg_addr));
      end
    end
  end

  // ---------------- monitor: pops expected outputs each cycle ---------------
  always @(negedge clk) begin : monitor
    logic [6:0] e, a;
    if (!rst && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      a = {fsync_o, active_chroma_o, active_video_o, hsync_o, vsync_o, hblank_o, vblank_o};
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL R2/R4/R5/R6/R7/R8 outputs h=%0d v=%0d act=%b exp=%b", m_h, m_v, a, e);
      end
    end
  end

  // ---------------- driver tasks ---------------------------------------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = model_read(int'(a));
    n_tests++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read addr %0d act=%h exp=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    n_tests++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read addr %0d act=%h exp=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired");
    summary();
  end

  // ---------------- stimulus ----------------------------------------------
  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state at the ports
    n_tests++;
    if ({fsync_o, active_chroma_o, active_video_o, hsync_o, vsync_o, hblank_o, vblank_o} !== 7'd0) begin
      n_fail++;
      $display("FAIL R10 outputs after reset act=%b exp=0", {fsync_o, active_chroma_o,
               active_video_o, hsync_o, vsync_o, hblank_o, vblank_o});
    end
    rd_expect(4'd0, 32'h0, "R10");
    rd_expect(4'd9, 32'h3F, "R10");
    rd_expect(4'd1, 32'h0, "R10");

    // program a small frame: 20 x 12, active 14 x 8
    wr(4'd2,  (32'd8 << 16) | 32'd14);
    wr(4'd3,  32'd20);
    wr(4'd4,  32'd12);
    wr(4'd5,  (32'd18 << 16) | 32'd15);
    wr(4'd6,  (32'd10 << 16) | 32'd9);
    wr(4'd7,  (32'd5 << 16) | 32'd3);
    wr(4'd8,  (32'd6 << 16) | 32'd2);
    wr(4'd10, (32'd2 << 16) | 32'd4);
    wr(4'd11, 32'hFFFF_FFFF);
    rd_expect(4'd5, (32'd18 << 16) | 32'd15, "R1");
    rd_expect(4'd11, 32'h0, "R1");
    rd_check(4'd7, "R1");
    // R3: update while disabled commits on the next edge
    wr(4'd0, 32'h2);
    rd_expect(4'd0, 32'h0, "R3");
    wr(4'd0, 32'h4);
    repeat (500) @(negedge clk);
    // R9: events have set the sticky bits
    rd_expect(4'd1, 32'h0001_3000, "R9");
    // R8: stop, then R9 clear with write-one
    wr(4'd0, 32'h0);
    repeat (3) @(negedge clk);
    wr(4'd1, 32'h0000_1000);
    rd_expect(4'd1, 32'h0001_2000, "R9");
    wr(4'd1, 32'h0001_2000);
    rd_expect(4'd1, 32'h0, "R9");

    // R3: mid-frame update waits for the frame boundary
    wr(4'd0, 32'h4);
    repeat (50) @(negedge clk);
    wr(4'd9, 32'h15);
    wr(4'd5, (32'd17 << 16) | 32'd16);
    wr(4'd0, 32'h6);
    rd_expect(4'd0, 32'h6, "R3");
    repeat (300) @(negedge clk);
    rd_expect(4'd0, 32'h4, "R3");
    rd_check(4'd1, "R9");

    // R6: zero offsets switch at line start; R7 pulse on the last pixel
    wr(4'd7, 32'h0);
    wr(4'd8, 32'h0);
    wr(4'd10, (32'd11 << 16) | 32'd19);
    wr(4'd9, 32'h3F);
    wr(4'd0, 32'h6);
    repeat (500) @(negedge clk);
    rd_check(4'd0, "R3");
    rd_check(4'd1, "R9");

    // R8: disabled generator holds inactive levels
    wr(4'd9, 32'h2A);
    wr(4'd0, 32'h2);
    repeat (20) @(negedge clk);
    rd_check(4'd9, "R8");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule